// File: doc/BRIEF.md
# Stereo Codec Serial Audio Port

This block is the slave side of a four-wire serial audio link for a 16-bit stereo codec. An external master drives a word clock, a bit clock and a serial data line into the block. The block drives a serial data line back out. All three inputs are brought into the core clock domain, and their edges are found there. The core clock must be several times faster than the bit clock.

Data arriving on the serial input is for the playback (digital-to-analog) path. It is packed right-justified: a sample ends on the last bit clock before the word clock changes. Bits that arrive earlier in the same half are padding and are discarded. Once both channels of a frame have arrived, the block presents the left and right samples together with a one-cycle strobe. On the return path, the block takes a left/right pair from the capture (analog-to-digital) side and sends it left-justified. The first bit of each sample goes out as soon as its half begins, and the line carries zeros once the sample has been sent.

A word-clock period may hold 32, 48 or 64 bit clocks, and this may change from one frame to the next. The bit clock and word clock are generated outside the block.

Top module: `stereo_serial_port`

## Requirements
- R1: While reset is held and after release, before any frame: `ser_data_o` is 0, `rx_valid_o` is 0, and both received words are 0.
- R2: A received sample is the last 16 bits sampled on rising bit-clock edges before the word clock changes, MSB first. Bits before those 16 in the same half do not affect the result.
- R3: Halves of 16, 24 or 32 bit clocks are accepted, and the half length may change between frames.
- R4: Word clock high marks the left channel, and left precedes right within a frame. A received pair is presented with `rx_valid_o` high for exactly one core cycle. This happens after the right half ends, when the first rising bit-clock edge of the next left half is seen.
- R5: No `rx_valid_o` pulse occurs until a complete left half has been received since reset. A lone right half after reset is dropped.
- R6: Transmission is left-justified, MSB first. Bit 15 of the channel's sample is driven after the word-clock edge that opens the half, and each following bit is driven after each falling bit-clock edge.
- R7: After the 16th bit of a half has been sent, `ser_data_o` is 0 for the remaining bit clocks of that half.
- R8: `tx_left_i` and `tx_right_i` are both taken at the rising word-clock edge that opens a left half. Changes to them later in that frame do not affect either transmitted half.
- R9: `rx_left_o` and `rx_right_o` change only in the cycle `rx_valid_o` rises, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, several times the bit-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_clk_i | input | 1 | Word clock from the master; high selects the left channel |
| bit_clk_i | input | 1 | Bit clock from the master |
| ser_data_i | input | 1 | Serial playback data, right-justified |
| ser_data_o | output | 1 | Serial capture data, left-justified |
| tx_left_i | input | 16 | Left sample to transmit, two's complement |
| tx_right_i | input | 16 | Right sample to transmit, two's complement |
| rx_left_o | output | 16 | Last received left sample |
| rx_right_o | output | 16 | Last received right sample |
| rx_valid_o | output | 1 | One-cycle strobe: a new received pair is present |

## Verification
The bench uses frames of 32, 48 and 64 bit clocks in a mixed order. Bit-exact checks on each half therefore separate a correct right-justified capture from one that counts bits from the start of the half. The padding bits are sent as all ones in some frames and as alternating values in others, with samples at both extremes (0x8000, 0x7FFF, 0x0000, 0xFFFF). This exposes any leak of padding into a sample and any swap of the left and right channels. The transmit samples are changed in the middle of every frame, so a design that samples them late is caught. A lone right half sent right after reset shows whether the first received pair is wrongly flagged as valid.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned SAMPLE_W = 16;
  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } chan_e;
  // positions of the three pins inside the synchronised bundle
  localparam int unsigned PIN_WCLK = 0;
  localparam int unsigned PIN_BCLK = 1;
  localparam int unsigned PIN_DATA = 2;
  localparam int unsigned PIN_CNT  = 3;
endpackage

// File: rtl/ssp_pin_sync.sv
module ssp_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] now_o,
  output logic [WIDTH-1:0] prev_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0][WIDTH-1:0] pipe_q;
  logic [DEPTH-1:0][WIDTH-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], pins_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign now_o  = pipe_q[STAGES-1];
  assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx
  import ssp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bit_stb_i,
  input  logic    wclk_i,
  input  logic    data_i,
  output sample_t left_o,
  output sample_t right_o,
  output logic    valid_o
);
  sample_t shift_q, shift_d;
  sample_t lhold_q, lhold_d;
  sample_t left_q, left_d;
  sample_t right_q, right_d;
  chan_e   side_q, side_d;
  logic    seen_q, seen_d;
  logic    valid_q, valid_d;

  always_comb begin
    shift_d = shift_q;
    lhold_d = lhold_q;
    left_d  = left_q;
    right_d = right_q;
    side_d  = side_q;
    seen_d  = seen_q;
    valid_d = 1'b0;
    if (bit_stb_i) begin
      if (chan_e'(wclk_i) != side_q) begin
        // the shift register holds the last SAMPLE_W bits of the closing half
        if (side_q == CH_LEFT) begin
          lhold_d = shift_q;
          seen_d  = 1'b1;
        end else if (seen_q) begin
          left_d  = lhold_q;
          right_d = shift_q;
          valid_d = 1'b1;
        end
      end
      shift_d = {shift_q[SAMPLE_W-2:0], data_i};
      side_d  = chan_e'(wclk_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      lhold_q <= '0;
      left_q  <= '0;
      right_q <= '0;
      side_q  <= CH_RIGHT;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      shift_q <= shift_d;
      lhold_q <= lhold_d;
      left_q  <= left_d;
      right_q <= right_d;
      side_q  <= side_d;
      seen_q  <= seen_d;
      valid_q <= valid_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
  import ssp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_stb_i,
  input  logic    wclk_i,
  input  logic    shift_stb_i,
  input  sample_t left_i,
  input  sample_t right_i,
  output logic    data_o
);
  sample_t shift_q, shift_d;
  sample_t rhold_q, rhold_d;

  always_comb begin
    shift_d = shift_q;
    rhold_d = rhold_q;
    if (load_stb_i) begin
      if (chan_e'(wclk_i) == CH_LEFT) begin
        shift_d = left_i;
        rhold_d = right_i;
      end else begin
        shift_d = rhold_q;
      end
    end else if (shift_stb_i) begin
      // zeros fill in behind the sample, so the tail of a long half is 0
      shift_d = {shift_q[SAMPLE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      rhold_q <= '0;
    end else begin
      shift_q <= shift_d;
      rhold_q <= rhold_d;
    end
  end

  assign data_o = shift_q[SAMPLE_W-1];
endmodule

// File: rtl/stereo_serial_port.sv
module stereo_serial_port
  import ssp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_clk_i,
  input  logic        bit_clk_i,
  input  logic        ser_data_i,
  output logic        ser_data_o,
  input  logic [15:0] tx_left_i,
  input  logic [15:0] tx_right_i,
  output logic [15:0] rx_left_o,
  output logic [15:0] rx_right_o,
  output logic        rx_valid_o
);
  logic [PIN_CNT-1:0] pins, pin_now, pin_prev;
  logic bclk_rise, bclk_fall, wclk_edge;

  always_comb begin
    pins           = '0;
    pins[PIN_WCLK] = word_clk_i;
    pins[PIN_BCLK] = bit_clk_i;
    pins[PIN_DATA] = ser_data_i;
  end

  ssp_pin_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_i (pins),
    .now_o  (pin_now),
    .prev_o (pin_prev)
  );

  assign bclk_rise = pin_now[PIN_BCLK] & ~pin_prev[PIN_BCLK];
  assign bclk_fall = ~pin_now[PIN_BCLK] & pin_prev[PIN_BCLK];
  assign wclk_edge = pin_now[PIN_WCLK] ^ pin_prev[PIN_WCLK];

  ssp_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb_i (bclk_rise),
    .wclk_i    (pin_now[PIN_WCLK]),
    .data_i    (pin_now[PIN_DATA]),
    .left_o    (rx_left_o),
    .right_o   (rx_right_o),
    .valid_o   (rx_valid_o)
  );

  ssp_tx u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_stb_i  (wclk_edge),
    .wclk_i      (pin_now[PIN_WCLK]),
    .shift_stb_i (bclk_fall),
    .left_i      (tx_left_i),
    .right_i     (tx_right_i),
    .data_o      (ser_data_o)
  );
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        word_clk_i,
  input logic        bit_clk_i,
  input logic        ser_data_o,
  input logic [15:0] rx_left_o,
  input logic [15:0] rx_right_o,
  input logic        rx_valid_o
);
  // R4: the strobe lasts one cycle
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R4: a pair is presented once the next left half has begun
  a_r4_strobe_in_left: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> word_clk_i);

  // R9: received words hold between strobes
  a_r9_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_o |-> ($stable(rx_left_o) && $stable(rx_right_o)));

  // R6: the serial output moves only during the low phase of the bit clock
  a_r6_out_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_data_o) |-> !bit_clk_i);
endmodule

bind stereo_serial_port ssp_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_clk_i (word_clk_i),
  .bit_clk_i  (bit_clk_i),
  .ser_data_o (ser_data_o),
  .rx_left_o  (rx_left_o),
  .rx_right_o (rx_right_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/sim_stereo_serial_port.sv
module sim_stereo_serial_port;
  logic clk = 1'b0;
  logic rst_n;
  logic wclk, bclk, sdi;
  logic sdo;
  logic [15:0] tx_l, tx_r, rx_l, rx_r;
  logic rx_v;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  logic [15:0] last_l = '0, last_r = '0;
  bit done = 0;

  always #5 clk = ~clk;

  stereo_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .word_clk_i(wclk), .bit_clk_i(bclk),
    .ser_data_i(sdi), .ser_data_o(sdo), .tx_left_i(tx_l), .tx_right_i(tx_r),
    .rx_left_o(rx_l), .rx_right_o(rx_r), .rx_valid_o(rx_v)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // every clock: compare received words against the model (R2, R4, R5, R9)
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (rx_v) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected strobe", {rx_l, rx_r}, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk({rx_l, rx_r} === e, "R2/R4 received pair", {rx_l, rx_r}, e);
          last_l = e[31:16];
          last_r = e[15:0];
        end
      end else begin
        chk({rx_l, rx_r} === {last_l, last_r}, "R9 words hold", {rx_l, rx_r}, {last_l, last_r});
      end
    end
  end

  // one half: lv = word clock level, n = bit clocks, rxs = sample sent in,
  // txs = sample expected out, jm = padding style, mid = change tx inputs midway
  task automatic send_half(input bit lv, input int n, input logic [15:0] rxs,
                           input logic [15:0] txs, input bit jm, input bit mid);
    for (int b = 0; b < n; b++) begin
      bclk = 1'b0;
      if (b == 0) wclk = lv;
      if (b >= n - 16) sdi = rxs[15 - (b - (n - 16))];
      else             sdi = jm ? 1'b1 : b[0];
      if (mid && b == 4) begin
        tx_l = ~tx_l;
        tx_r = tx_r ^ 16'h5A5A;
      end
      repeat (6) @(negedge clk);
      if (b < 16) chk(sdo === txs[15 - b], "R6 transmit bit", {31'd0, sdo}, {31'd0, txs[15 - b]});
      else        chk(sdo === 1'b0, "R7 zero tail", {31'd0, sdo}, 32'd0);
      bclk = 1'b1;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic frame(input int n, input logic [15:0] rl, input logic [15:0] rr,
                       input logic [15:0] tl, input logic [15:0] tr, input bit jm);
    tx_l = tl;
    tx_r = tr;
    // R3: half length n of 16, 24 or 32; R8: inputs disturbed after the load
    send_half(1'b1, n, rl, tl, jm, 1'b1);
    send_half(1'b0, n, rr, tr, ~jm, 1'b0);
    exp_q.push_back({rl, rr});
  endtask

  initial begin
    rst_n = 1'b0;
    wclk = 1'b0; bclk = 1'b1; sdi = 1'b0;
    tx_l = 16'h1111; tx_r = 16'h2222;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(sdo === 1'b0 && rx_v === 1'b0, "R1 reset outputs", {30'd0, sdo, rx_v}, 32'd0);
    chk({rx_l, rx_r} === 32'h0, "R1 reset words", {rx_l, rx_r}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R5: a lone right half after reset yields no pair; nothing loaded yet so output is 0 (R1)
    send_half(1'b0, 16, 16'hDEAD, 16'h0000, 1'b1, 1'b0);
    frame(16, 16'h8001, 16'h7FFE, 16'hA5C3, 16'h0F0F, 1'b0);
    frame(24, 16'h1234, 16'hFEDC, 16'hFFFF, 16'h0000, 1'b1);
    frame(32, 16'h0000, 16'hFFFF, 16'h8000, 16'h0001, 1'b1);
    frame(32, 16'hFFFF, 16'h0000, 16'h5A5A, 16'hC3C3, 1'b0);
    frame(16, 16'h7FFF, 16'h8000, 16'h0001, 16'h8000, 1'b1);
    frame(24, 16'h0F0F, 16'hF0F0, 16'h7FFF, 16'hFFFE, 1'b0);
    for (int k = 0; k < 6; k++) begin
      frame(16 + 8 * (k % 3), 16'h1357 * (k + 3), 16'hACE1 ^ (16'h0101 << k),
            16'h2468 + 16'(k * 977), 16'hBEEF - 16'(k * 313), k[0]);
    end
    // opening of one more left half completes the last frame
    tx_l = 16'hC001; tx_r = 16'h0000;
    send_half(1'b1, 2, 16'h0000, 16'hC001, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all pairs presented", exp_q.size(), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule